// File: doc/BRIEF.md
# Coprocessor Instruction Dispatch and Trap Controller

This block sits between a CPU decode stage and a coprocessor that is reached through memory-mapped registers. It accepts one opcode at a time from the coprocessor opcode group (top nibble `1111`). It first classifies the encoding. An unusable encoding raises an emulation trap before the coprocessor is touched. A usable one is written to the coprocessor command register, and the block then polls the response register. Each returned primitive is checked against the instruction form and its effective-address (EA) mode.

A primitive that does not fit is handled in two steps. The block first writes an abort mask to the control register, and only then raises the trap. A bus error on the command write is taken to mean that no coprocessor is fitted. Every trap carries a fixed vector, a fixed frame format and the address of the faulting instruction, so that an unmodified return re-executes that instruction. A cause code separates the three paths: trap before any contact, coprocessor absent, and aborted dialogue.

Top module: `cp_dispatch`

## Requirements
- R1: After reset, `op_ready_o` is 1 and `bus_req_o` and `trap_o` are 0.
- R2: An opcode whose bits [15:12] are not `1111`, or whose bits [8:6] are `110` or `111`, raises a trap with cause 1 and makes no access to the register bus.
- R3: Bits [8:6] select the form and bits [5:3]/[2:0] give the EA mode/register. Forms `000` (general) and `001` (conditional) accept every EA except mode 7 with register 5 to 7. Forms `010` and `011` (branches) accept any low six bits. Form `100` (save) accepts only (An), -(An), d16(An), indexed, abs.W and abs.L. Form `101` (restore) accepts only (An), (An)+, d16(An), indexed, abs.W, abs.L, PC-d16 and PC-indexed. Any other form/EA pair traps with cause 1 and makes no bus access.
- R4: An accepted opcode produces exactly one write to the command register (select 0) with the opcode as data. It is followed by reads of the response register (select 2). The control register (select 1) is not written on normal completion. A request holds its select and direction until `bus_ready_i` or `bus_err_i`.
- R5: A primitive uses bits [15:13] as its type, and bits [12:0] must be zero. The types behave as follows:
  - Type 0 completes the instruction: `done_o` is high for one cycle and the block returns to idle.
  - Type 1 (busy) causes another read.
  - Type 2 (evaluate EA) is valid only for a non-branch form with a memory EA (mode 2 to 7), and then causes another read.
  - Type 3 (register transfer) is valid only for a non-branch form with EA mode 0 or 1, and then causes another read.
- R6: An invalid primitive (type 4 to 7, a type that does not fit as in R5, nonzero bits [12:0]), or a bus error on a response read, leads to one write of the abort mask (default `0x0001`) to the control register, followed by a trap with cause 3.
- R7: A bus error on the command write raises a trap with cause 2, and the control register is never written.
- R8: Every trap reports vector 11 and frame format 0, and `trap_pc_o` equals the `op_pc_i` that came with the faulting opcode.
- R9: `trap_cause_o` is 1 for a trap before any contact, 2 for an absent coprocessor and 3 for an aborted dialogue.
- R10: `op_ready_o` is 0 from acceptance until the block returns to idle. `trap_o` rises once per faulting opcode and stays high with stable information until `trap_ack_i`. Opcodes offered meanwhile are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | Opcode offered |
| op_ready_o | output | 1 | Block idle, opcode taken this cycle if valid |
| opcode_i | input | 16 | Instruction operation word |
| op_pc_i | input | PC_W | Address of the offered instruction |
| bus_req_o | output | 1 | Register access request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_sel_o | output | 2 | Register select: 0 command, 1 control, 2 response |
| bus_wdata_o | output | 16 | Write data |
| bus_ready_i | input | 1 | Access completed |
| bus_err_i | input | 1 | Access terminated by bus error |
| bus_rdata_i | input | 16 | Response primitive read data |
| done_o | output | 1 | One-cycle pulse on normal completion |
| trap_o | output | 1 | Trap request, held until acknowledged |
| trap_ack_i | input | 1 | Trap acknowledge |
| trap_vec_o | output | 8 | Trap vector number |
| trap_fmt_o | output | 4 | Stack frame format code |
| trap_pc_o | output | PC_W | Saved address of the faulting instruction |
| trap_cause_o | output | 2 | Trap cause code |

## Verification
The bench targets the three trap paths and the distinctions between them.

- **Bus contact before a pre-dialogue trap.** Illegal forms, illegal EA pairs and opcodes outside the group must leave the bus untouched. A design that wrote the command register first would show a bus access, or the wrong cause.
- **Abort ordering.** Mismatched primitives must produce exactly one control write of the abort mask before the trap. A swapped order, or a missing abort, shows up as a wrong control-write count or a wrong cause.
- **Bus errors.** A command write that ends in a bus error must not be followed by an abort write.
- **Legal encodings that still complete.** Branches with arbitrary low bits, restore with PC-relative EA, and register transfers with a register EA must finish normally. A mask that was too strict would trap them.
- **Trap hand-back.** The bench offers new opcodes while a trap is pending. This catches a design that re-arms, changes the saved address, or accepts work before the acknowledge.

// File: rtl/cp_dispatch_pkg.sv
package cp_dispatch_pkg;
  localparam int OP_W = 16;
  localparam int DATA_W = 16;
  localparam int SEL_W = 2;
  localparam int EA_CLASSES = 12;
  localparam int FORMS = 8;

  typedef enum logic [2:0] {
    S_IDLE, S_CLASSIFY, S_WRITE_CMD, S_WAIT_RESP, S_CHECK_PRIM, S_ABORT_WRITE, S_TRAP
  } cp_state_e;

  localparam logic [SEL_W-1:0] SEL_CMD  = 2'd0;
  localparam logic [SEL_W-1:0] SEL_CTRL = 2'd1;
  localparam logic [SEL_W-1:0] SEL_RESP = 2'd2;

  localparam logic [1:0] CAUSE_NONE   = 2'd0;
  localparam logic [1:0] CAUSE_PRE    = 2'd1;
  localparam logic [1:0] CAUSE_ABSENT = 2'd2;
  localparam logic [1:0] CAUSE_ABORT  = 2'd3;

  localparam logic [2:0] PRIM_DONE = 3'd0;
  localparam logic [2:0] PRIM_BUSY = 3'd1;
  localparam logic [2:0] PRIM_EVAL = 3'd2;
  localparam logic [2:0] PRIM_XREG = 3'd3;

  // EA class bit: 0 Dn,1 An,2 (An),3 (An)+,4 -(An),5 d16,6 idx,7 abs.W,8 abs.L,9 PC-d16,10 PC-idx,11 imm
  localparam logic [EA_CLASSES-1:0] MASK_ANY     = 12'hFFF;
  localparam logic [EA_CLASSES-1:0] MASK_SAVE    = 12'h1F4;
  localparam logic [EA_CLASSES-1:0] MASK_RESTORE = 12'h7EC;
endpackage

// File: rtl/cp_classify.sv
module cp_classify
  import cp_dispatch_pkg::*;
(
  input  logic [3:0] group_i,
  input  logic [8:0] low_i,
  output logic       legal_o,
  output logic       is_branch_o,
  output logic       ea_mem_o,
  output logic       ea_reg_o
);
  logic [2:0] form, mode, rsel;
  logic       ea_ok;
  logic [3:0] ea_idx;
  logic [EA_CLASSES-1:0] form_mask [FORMS];

  assign form = low_i[8:6];
  assign mode = low_i[5:3];
  assign rsel = low_i[2:0];

  for (genvar f = 0; f < FORMS; f++) begin : g_mask
    if (f == 4)      begin : g_save assign form_mask[f] = MASK_SAVE;    end
    else if (f == 5) begin : g_rest assign form_mask[f] = MASK_RESTORE; end
    else if (f < 4)  begin : g_any  assign form_mask[f] = MASK_ANY;     end
    else             begin : g_none assign form_mask[f] = '0;           end
  end

  assign ea_ok       = (mode != 3'd7) || (rsel <= 3'd4);
  assign ea_idx      = !ea_ok ? 4'd0 : (mode != 3'd7) ? {1'b0, mode} : 4'd7 + {1'b0, rsel};
  assign is_branch_o = (form == 3'd2) || (form == 3'd3);
  assign ea_mem_o    = ea_ok && (mode >= 3'd2);
  assign ea_reg_o    = (mode <= 3'd1);
  assign legal_o     = (group_i == 4'hF) &&
                       (is_branch_o || (ea_ok && form_mask[form][ea_idx]));
endmodule

// File: rtl/cp_prim_check.sv
module cp_prim_check
  import cp_dispatch_pkg::*;
(
  input  logic [DATA_W-1:0] prim_i,
  input  logic              is_branch_i,
  input  logic              ea_mem_i,
  input  logic              ea_reg_i,
  output logic              done_o,
  output logic              again_o,
  output logic              bad_o
);
  logic [2:0] ptype;
  logic       rsvd_clear;

  assign ptype      = prim_i[DATA_W-1 -: 3];
  assign rsvd_clear = (prim_i[DATA_W-4:0] == '0);

  always_comb begin
    done_o  = 1'b0;
    again_o = 1'b0;
    bad_o   = 1'b0;
    if (!rsvd_clear) bad_o = 1'b1;
    else begin
      case (ptype)
        PRIM_DONE: done_o  = 1'b1;
        PRIM_BUSY: again_o = 1'b1;
        PRIM_EVAL: if (!is_branch_i && ea_mem_i) again_o = 1'b1; else bad_o = 1'b1;
        PRIM_XREG: if (!is_branch_i && ea_reg_i) again_o = 1'b1; else bad_o = 1'b1;
        default:   bad_o = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/cp_dispatch.sv
module cp_dispatch
  import cp_dispatch_pkg::*;
#(
  parameter int                PC_W       = 32,
  parameter logic [DATA_W-1:0] ABORT_MASK = 16'h0001,
  parameter int                VEC_W      = 8,
  parameter logic [VEC_W-1:0]  TRAP_VEC   = 8'd11,
  parameter int                FMT_W      = 4,
  parameter logic [FMT_W-1:0]  TRAP_FMT   = 4'd0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  output logic              op_ready_o,
  input  logic [OP_W-1:0]   opcode_i,
  input  logic [PC_W-1:0]   op_pc_i,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [SEL_W-1:0]  bus_sel_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              bus_ready_i,
  input  logic              bus_err_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              done_o,
  output logic              trap_o,
  input  logic              trap_ack_i,
  output logic [VEC_W-1:0]  trap_vec_o,
  output logic [FMT_W-1:0]  trap_fmt_o,
  output logic [PC_W-1:0]   trap_pc_o,
  output logic [1:0]        trap_cause_o
);
  cp_state_e         state_q, state_d;
  logic [OP_W-1:0]   op_q;
  logic [PC_W-1:0]   pc_q;
  logic [DATA_W-1:0] prim_q;
  logic [1:0]        cause_q, cause_d;
  logic              legal, is_branch, ea_mem, ea_reg;
  logic              p_done, p_again, p_bad;
  logic              bus_end;

  cp_classify u_classify (
    .group_i    (op_q[15:12]),
    .low_i      (op_q[8:0]),
    .legal_o    (legal),
    .is_branch_o(is_branch),
    .ea_mem_o   (ea_mem),
    .ea_reg_o   (ea_reg)
  );

  cp_prim_check u_prim (
    .prim_i     (prim_q),
    .is_branch_i(is_branch),
    .ea_mem_i   (ea_mem),
    .ea_reg_i   (ea_reg),
    .done_o     (p_done),
    .again_o    (p_again),
    .bad_o      (p_bad)
  );

  assign bus_end = bus_ready_i || bus_err_i;

  always_comb begin
    state_d = state_q;
    cause_d = cause_q;
    unique case (state_q)
      S_IDLE:       if (op_valid_i) state_d = S_CLASSIFY;
      S_CLASSIFY:   if (legal) state_d = S_WRITE_CMD;
                    else begin state_d = S_TRAP; cause_d = CAUSE_PRE; end
      S_WRITE_CMD:  if (bus_err_i) begin state_d = S_TRAP; cause_d = CAUSE_ABSENT; end
                    else if (bus_ready_i) state_d = S_WAIT_RESP;
      S_WAIT_RESP:  if (bus_err_i) state_d = S_ABORT_WRITE;
                    else if (bus_ready_i) state_d = S_CHECK_PRIM;
      S_CHECK_PRIM: if (p_bad) state_d = S_ABORT_WRITE;
                    else if (p_again) state_d = S_WAIT_RESP;
                    else if (p_done) state_d = S_IDLE;
      S_ABORT_WRITE: if (bus_end) begin state_d = S_TRAP; cause_d = CAUSE_ABORT; end
      S_TRAP:       if (trap_ack_i) state_d = S_IDLE;
      default:      state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cause_q <= CAUSE_NONE;
      op_q    <= '0;
      pc_q    <= '0;
      prim_q  <= '0;
    end else begin
      state_q <= state_d;
      cause_q <= cause_d;
      if (state_q == S_IDLE && op_valid_i) begin
        op_q <= opcode_i;
        pc_q <= op_pc_i;
      end
      if (state_q == S_WAIT_RESP && bus_ready_i && !bus_err_i) prim_q <= bus_rdata_i;
    end
  end

  assign op_ready_o   = (state_q == S_IDLE);
  assign bus_req_o    = (state_q == S_WRITE_CMD) || (state_q == S_WAIT_RESP) ||
                        (state_q == S_ABORT_WRITE);
  assign bus_we_o     = (state_q == S_WRITE_CMD) || (state_q == S_ABORT_WRITE);
  assign bus_sel_o    = (state_q == S_WAIT_RESP)   ? SEL_RESP :
                        (state_q == S_ABORT_WRITE) ? SEL_CTRL : SEL_CMD;
  assign bus_wdata_o  = (state_q == S_ABORT_WRITE) ? ABORT_MASK : op_q;
  assign done_o       = (state_q == S_CHECK_PRIM) && p_done && !p_bad;
  assign trap_o       = (state_q == S_TRAP);
  assign trap_vec_o   = TRAP_VEC;
  assign trap_fmt_o   = TRAP_FMT;
  assign trap_pc_o    = pc_q;
  assign trap_cause_o = cause_q;
endmodule

// File: rtl/cp_dispatch_chk.sv
module cp_dispatch_chk
  import cp_dispatch_pkg::*;
#(
  parameter int PC_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             op_valid_i,
  input logic             op_ready_o,
  input logic [PC_W-1:0]  op_pc_i,
  input logic             bus_req_o,
  input logic             bus_we_o,
  input logic [SEL_W-1:0] bus_sel_o,
  input logic             bus_ready_i,
  input logic             bus_err_i,
  input logic             done_o,
  input logic             trap_o,
  input logic             trap_ack_i,
  input logic [PC_W-1:0]  trap_pc_o,
  input logic [1:0]       trap_cause_o
);
  logic            bus_seen, ctrl_seen;
  logic [PC_W-1:0] pc_cap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_seen  <= 1'b0;
      ctrl_seen <= 1'b0;
      pc_cap    <= '0;
    end else if (op_valid_i && op_ready_o) begin
      bus_seen  <= 1'b0;
      ctrl_seen <= 1'b0;
      pc_cap    <= op_pc_i;
    end else begin
      if (bus_req_o) bus_seen <= 1'b1;
      if (bus_req_o && bus_we_o && bus_sel_o == SEL_CTRL && (bus_ready_i || bus_err_i))
        ctrl_seen <= 1'b1;
    end
  end

  a_r2_pre_trap_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_o && trap_cause_o == CAUSE_PRE) |-> !bus_seen);
  a_r7_absent_no_ctrl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_o && trap_cause_o == CAUSE_ABSENT) |-> !ctrl_seen);
  a_r6_abort_before_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_o && trap_cause_o == CAUSE_ABORT) |-> ctrl_seen);
  a_r8_trap_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> trap_pc_o == pc_cap);
  a_r10_trap_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_o && !trap_ack_i) |=> (trap_o && $stable(trap_pc_o) && $stable(trap_cause_o)));
  a_r10_no_accept_in_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> !op_ready_o);
  a_r5_done_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> op_ready_o);
  a_r4_bus_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ready_i && !bus_err_i) |=>
      (bus_req_o && $stable(bus_sel_o) && $stable(bus_we_o)));
endmodule

bind cp_dispatch cp_dispatch_chk #(.PC_W(PC_W)) chk_i (.*);

// File: tb/cp_dispatch_tb_top.sv
module cp_dispatch_tb_top;
  import cp_dispatch_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 32;
  localparam logic [15:0] ABORT_VAL = 16'h0001;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic op_valid_i = 1'b0, op_ready_o;
  logic [15:0] opcode_i = '0;
  logic [PC_W-1:0] op_pc_i = '0;
  logic bus_req_o, bus_we_o;
  logic [1:0] bus_sel_o;
  logic [15:0] bus_wdata_o, bus_rdata_i = '0;
  logic bus_ready_i = 1'b0, bus_err_i = 1'b0;
  logic done_o, trap_o, trap_ack_i = 1'b0;
  logic [7:0] trap_vec_o;
  logic [3:0] trap_fmt_o;
  logic [PC_W-1:0] trap_pc_o;
  logic [1:0] trap_cause_o;

  cp_dispatch dut_i (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  logic [15:0] script [8];
  int rd_idx, n_acc, n_cmd, n_ctrl;
  logic [15:0] cmd_data, ctrl_data;
  bit err_cmd = 0, err_resp = 0;

  // Zero-wait register model: completes whatever is requested at the next edge
  always @(negedge clk_i) begin
    bus_ready_i = 1'b0;
    bus_err_i   = 1'b0;
    if (bus_req_o) begin
      n_acc++;
      if (bus_we_o) begin
        if (bus_sel_o == SEL_CMD) begin
          n_cmd++; cmd_data = bus_wdata_o;
          if (err_cmd) bus_err_i = 1'b1; else bus_ready_i = 1'b1;
        end else begin
          n_ctrl++; ctrl_data = bus_wdata_o; bus_ready_i = 1'b1;
        end
      end else begin
        bus_rdata_i = script[rd_idx];
        if (rd_idx < 7) rd_idx++;
        if (err_resp) bus_err_i = 1'b1; else bus_ready_i = 1'b1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic set_script(input logic [15:0] a, input logic [15:0] b, input logic [15:0] c);
    script[0] = a; script[1] = b; script[2] = c;
    for (int i = 3; i < 8; i++) script[i] = 16'h0000;
  endtask

  task automatic run_op(input logic [15:0] op, input logic [PC_W-1:0] pc, input bit exp_trap,
                        input logic [1:0] exp_cause, input int exp_cmd, input int exp_ctrl,
                        input string req);
    int rises = 0, acc_hold;
    bit seen_done = 0, seen_trap = 0, prev = 0;
    rd_idx = 0; n_acc = 0; n_cmd = 0; n_ctrl = 0; cmd_data = '0; ctrl_data = '0;
    @(negedge clk_i);
    op_valid_i = 1'b1; opcode_i = op; op_pc_i = pc;
    @(negedge clk_i);
    op_valid_i = 1'b0;
    chk(!op_ready_o, "R10", "busy after accept", op_ready_o, 0);
    for (int i = 0; i < 60 && !seen_done && !seen_trap; i++) begin
      if (trap_o && !prev) rises++;
      prev = trap_o;
      if (done_o) seen_done = 1;
      if (trap_o) seen_trap = 1;
      if (!seen_done && !seen_trap) @(negedge clk_i);
    end
    chk(seen_trap == exp_trap && seen_done != exp_trap, req, "trap outcome", seen_trap, exp_trap);
    chk(n_cmd == exp_cmd, req, "command writes", n_cmd, exp_cmd);
    chk(n_ctrl == exp_ctrl, req, "control writes", n_ctrl, exp_ctrl);
    if (exp_trap && exp_cause == CAUSE_PRE) chk(n_acc == 0, req, "bus accesses", n_acc, 0);
    if (exp_cmd > 0) chk(cmd_data == op, "R4", "command data", cmd_data, op);
    if (exp_ctrl > 0) chk(ctrl_data == ABORT_VAL, "R6", "abort mask", ctrl_data, ABORT_VAL);
    if (seen_done) begin
      @(negedge clk_i);
      chk(!done_o && op_ready_o, "R5", "done one cycle then idle", {done_o, op_ready_o}, 2'b01);
    end
    if (seen_trap) begin
      chk(trap_cause_o == exp_cause, "R9", "cause", trap_cause_o, exp_cause);
      chk(trap_vec_o == 8'd11 && trap_fmt_o == 4'd0, "R8", "vector/format",
          {trap_vec_o, trap_fmt_o}, {8'd11, 4'd0});
      chk(trap_pc_o == pc, "R8", "saved pc", trap_pc_o, pc);
      acc_hold = n_acc;
      op_valid_i = 1'b1; opcode_i = 16'hF000; op_pc_i = ~pc;
      for (int i = 0; i < 3; i++) begin
        @(negedge clk_i);
        if (trap_o && !prev) rises++;
        prev = trap_o;
      end
      op_valid_i = 1'b0;
      chk(trap_o && !op_ready_o && trap_pc_o == pc && trap_cause_o == exp_cause && n_acc == acc_hold,
          "R10", "held until ack, offers ignored", {trap_o, op_ready_o}, 2'b10);
      trap_ack_i = 1'b1;
      @(negedge clk_i);
      trap_ack_i = 1'b0;
      chk(!trap_o && op_ready_o && !bus_req_o, "R10", "release after ack",
          {trap_o, op_ready_o, bus_req_o}, 3'b010);
      chk(rises == 1, "R10", "single trap rise", rises, 1);
    end
  endtask

  task automatic t_reset();
    chk(op_ready_o && !bus_req_o && !trap_o, "R1", "reset state",
        {op_ready_o, bus_req_o, trap_o}, 3'b100);
  endtask

  task automatic t_pre_dialogue();
    run_op(16'hF180, 32'h0000_1000, 1, CAUSE_PRE, 0, 0, "R2");  // form 110
    run_op(16'hF1C0, 32'h0000_1004, 1, CAUSE_PRE, 0, 0, "R2");  // form 111
    run_op(16'hE000, 32'h0000_1008, 1, CAUSE_PRE, 0, 0, "R2");  // outside group
    run_op(16'hF03D, 32'h0000_100C, 1, CAUSE_PRE, 0, 0, "R3");  // general, mode7 reg5
    run_op(16'hF100, 32'h0000_1010, 1, CAUSE_PRE, 0, 0, "R3");  // save with Dn
    run_op(16'hF160, 32'h0000_1014, 1, CAUSE_PRE, 0, 0, "R3");  // restore with -(An)
  endtask

  task automatic t_complete();
    set_script(16'h2000, 16'h0000, 16'h0000);
    run_op(16'hF000, 32'h0000_2000, 0, CAUSE_NONE, 1, 0, "R4");  // busy then done
    set_script(16'h4000, 16'h0000, 16'h0000);
    run_op(16'hF110, 32'h0000_2004, 0, CAUSE_NONE, 1, 0, "R5");  // save (A0), eval EA
    set_script(16'h0000, 16'h0000, 16'h0000);
    run_op(16'hF0BF, 32'h0000_2008, 0, CAUSE_NONE, 1, 0, "R3");  // branch, any low bits
    set_script(16'h0000, 16'h0000, 16'h0000);
    run_op(16'hF17A, 32'h0000_200C, 0, CAUSE_NONE, 1, 0, "R3");  // restore PC-d16
    set_script(16'h6000, 16'h0000, 16'h0000);
    run_op(16'hF000, 32'h0000_2010, 0, CAUSE_NONE, 1, 0, "R5");  // reg transfer with Dn
  endtask

  task automatic t_absent();
    err_cmd = 1;
    run_op(16'hF000, 32'h0000_3000, 1, CAUSE_ABSENT, 1, 0, "R7");
    err_cmd = 0;
  endtask

  task automatic t_abort();
    set_script(16'h8000, 16'h0000, 16'h0000);
    run_op(16'hF000, 32'h0000_4000, 1, CAUSE_ABORT, 1, 1, "R6");  // type 4
    set_script(16'h2000, 16'h6000, 16'h0000);
    run_op(16'hF010, 32'h0000_4004, 1, CAUSE_ABORT, 1, 1, "R5");  // reg xfer on (A0)
    set_script(16'h4000, 16'h0000, 16'h0000);
    run_op(16'hF080, 32'h0000_4008, 1, CAUSE_ABORT, 1, 1, "R5");  // eval EA on branch
    set_script(16'h0001, 16'h0000, 16'h0000);
    run_op(16'hF000, 32'h0000_400C, 1, CAUSE_ABORT, 1, 1, "R6");  // reserved bits set
    err_resp = 1;
    set_script(16'h0000, 16'h0000, 16'h0000);
    run_op(16'hF000, 32'h0000_4010, 1, CAUSE_ABORT, 1, 1, "R6");  // bus error on read
    err_resp = 0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL R10 watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_pre_dialogue();
    t_complete();
    t_absent();
    t_abort();
    repeat (2) @(negedge clk_i);
    summary();
    $finish;
  end
endmodule